// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. An upstream parser pulls the address out of the frame and presents it with a one-cycle strobe. One clock later the block reports three things: accept or reject, whether an exact-match slot hit (and which slot), and whether the multicast hash table hit.

The block holds a pool of exact-match address slots. A programmable count splits this pool. Slots below the count serve unicast addresses, and slot 0 normally holds the station's own address. Slots at or above the count serve multicast addresses. Multicast groups that do not fit in the pool fall back to a 64-bin table. The table is indexed by a 6-bit XOR fold of all 48 address bits.

Three mode bits modify the decision:
- a copy-all mode accepts every frame;
- a hash enable gates table hits;
- a broadcast disable rejects the all-ones address.

Setting both hash words to all ones gives an accept-all-multicast setting. A plain write port loads the slots, the hash words, the mode bits and the unicast count.

Top module: `rx_dest_filter`

## Requirements
- R1: `res_vld` is high in the cycle after `rx_addr_vld` was high, and low otherwise. The result fields belong to the address presented in that earlier cycle.
- R2: Slot k is written through two register addresses, as follows. The low word is at 2k and holds address bytes 0..3 in bits 7:0, 15:8, 23:16 and 31:24. The high word is at 2k+1 and holds byte 4 in bits 7:0 and byte 5 in bits 15:8. On `rx_addr`, byte j sits in bits 8j+7:8j.
- R3: Writing a slot's low word marks the slot invalid. Writing its high word marks the slot valid, unless both the new high word and the stored low word are zero, in which case the slot stays invalid. An invalid slot never hits.
- R4: The unicast count lives at register 19 and resets to 1. A write with a value above 8 is ignored. Slots with index below the count hit only unicast addresses (byte 0 bit 0 clear). The other slots hit only multicast addresses (byte 0 bit 0 set).
- R5: When several slots hit, `res_slot` reports the lowest index and `res_exact` is high.
- R6: The hash index is computed as follows. Bit n of the address (byte 0 LSB first, up through byte 5) is XORed into index bit n mod 6.
- R7: The hash table is held in two words. Register 16 holds bins 0..31, with bin i in bit i. Register 17 holds bins 32..63, with bin i in bit i-32.
- R8: `res_hash` is high only when all three of these hold: the address is multicast, hash enable (register 18 bit 1) is set, and the indexed bin is set.
- R9: With copy-all (register 18 bit 0) set, every address is accepted.
- R10: The all-ones address is handled as follows when copy-all is clear. It is rejected while broadcast disable (register 18 bit 2) is set and accepted otherwise. Any other address is accepted exactly when `res_exact` or `res_hash` is high.
- R11: After reset the state is as follows:
  - all slots are invalid;
  - both hash words and all mode bits are zero;
  - all result outputs are low.
- R12: A configuration write in the same cycle as an address strobe does not affect that lookup. The lookup uses the settings held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| rx_addr_vld | input | 1 | Destination address strobe |
| rx_addr | input | 48 | Destination address, byte j in bits 8j+7:8j |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_exact | output | 1 | An exact-match slot hit |
| res_slot | output | 3 | Lowest hitting slot index |
| res_hash | output | 1 | Multicast hash bin hit |

## Verification
The bench targets the following corner cases:
- a half-written slot, which must not match;
- the same group loaded in two slots, which exposes a priority encoder that picks the wrong end;
- a unicast count moved across a loaded slot, or set out of range, where a design without the range check would reinterpret every slot;
- a unicast address whose hash bin happens to be set, which a filter that forgets the multicast check would wrongly accept;
- configuration writes landing in the same cycle as a strobe, where a design that reads the new value would report a result the lookup never saw.

Bins on both sides of index 32 are exercised, so a swapped hash word shows up as missed multicast frames.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int ADDR_W = 48;
  localparam int HASH_W = 6;
  localparam int WORD_W = 32;
  localparam int HIGH_W = ADDR_W - WORD_W;

  // XOR fold of every address bit into a 6-bit bin index.
  function automatic logic [HASH_W-1:0] fold_hash(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int j = 0; j < ADDR_W; j++) h[j % HASH_W] = h[j % HASH_W] ^ a[j];
    return h;
  endfunction

  function automatic logic is_group(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction
endpackage

// File: rtl/rdf_slot_bank.sv
module rdf_slot_bank
  import rdf_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SIW = $clog2(NSLOT),
  localparam int UW  = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIW-1:0]    wr_idx,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [UW-1:0]     ucnt,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SIW-1:0]    hit_idx
);
  logic [WORD_W-1:0] lo_q [NSLOT];
  logic [HIGH_W-1:0] hi_q [NSLOT];
  logic [NSLOT-1:0]  val_q;
  logic [NSLOT-1:0]  match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        lo_q[k] <= '0;
        hi_q[k] <= '0;
      end
    end else if (wr_en) begin
      for (int k = 0; k < NSLOT; k++) begin
        if (wr_idx == SIW'(k)) begin
          if (!wr_hi) begin
            lo_q[k]  <= wr_data;
            val_q[k] <= 1'b0;
          end else begin
            hi_q[k]  <= wr_data[HIGH_W-1:0];
            val_q[k] <= (wr_data[HIGH_W-1:0] != '0) || (lo_q[k] != '0);
          end
        end
      end
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_cmp
    logic uc_slot;
    assign uc_slot  = UW'(k) < ucnt;
    assign match[k] = val_q[k] && ({hi_q[k], lo_q[k]} == addr) &&
                      (uc_slot ? !is_group(addr) : is_group(addr));
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (match[i]) hit_idx = SIW'(i);
  end
endmodule

// File: rtl/rdf_hash_table.sv
module rdf_hash_table
  import rdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              bin_set
);
  logic [WORD_W-1:0] lo_q, hi_q;
  logic [HASH_W-1:0] bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= wr_data;
    end
  end

  assign bin     = fold_hash(addr);
  assign bin_set = bin[HASH_W-1] ? hi_q[bin[HASH_W-2:0]] : lo_q[bin[HASH_W-2:0]];
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rdf_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SIW  = $clog2(NSLOT),
  localparam int UW   = $clog2(NSLOT + 1),
  localparam int NREG = 2 * NSLOT + 4,
  localparam int CAW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              rx_addr_vld,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              res_vld,
  output logic              res_accept,
  output logic              res_exact,
  output logic [SIW-1:0]    res_slot,
  output logic              res_hash
);
  localparam logic [CAW-1:0] A_HLO  = CAW'(2 * NSLOT);
  localparam logic [CAW-1:0] A_HHI  = CAW'(2 * NSLOT + 1);
  localparam logic [CAW-1:0] A_MODE = CAW'(2 * NSLOT + 2);
  localparam logic [CAW-1:0] A_UCNT = CAW'(2 * NSLOT + 3);

  logic          mode_promisc, mode_hash_en, mode_bcast_dis;
  logic [UW-1:0] ucnt_q;
  logic          slot_we, slot_hit, bin_set, hash_ok;
  logic          addr_mcast, addr_bcast, decide;
  logic [SIW-1:0] slot_idx;

  assign slot_we = cfg_we && (cfg_addr < A_HLO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_promisc   <= 1'b0;
      mode_hash_en   <= 1'b0;
      mode_bcast_dis <= 1'b0;
      ucnt_q         <= UW'(1);
    end else if (cfg_we) begin
      if (cfg_addr == A_MODE) begin
        mode_promisc   <= cfg_wdata[0];
        mode_hash_en   <= cfg_wdata[1];
        mode_bcast_dis <= cfg_wdata[2];
      end
      if (cfg_addr == A_UCNT && cfg_wdata <= WORD_W'(NSLOT))
        ucnt_q <= cfg_wdata[UW-1:0];
    end
  end

  rdf_slot_bank #(.NSLOT(NSLOT)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (slot_we),
    .wr_idx  (cfg_addr[SIW:1]),
    .wr_hi   (cfg_addr[0]),
    .wr_data (cfg_wdata),
    .ucnt    (ucnt_q),
    .addr    (rx_addr),
    .hit     (slot_hit),
    .hit_idx (slot_idx)
  );

  rdf_hash_table u_hash (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (cfg_we && cfg_addr == A_HLO),
    .wr_hi   (cfg_we && cfg_addr == A_HHI),
    .wr_data (cfg_wdata),
    .addr    (rx_addr),
    .bin_set (bin_set)
  );

  assign addr_mcast = is_group(rx_addr);
  assign addr_bcast = &rx_addr;
  assign hash_ok    = addr_mcast && mode_hash_en && bin_set;
  assign decide     = mode_promisc ||
                      (addr_bcast ? !mode_bcast_dis : (slot_hit || hash_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_accept <= 1'b0;
      res_exact  <= 1'b0;
      res_slot   <= '0;
      res_hash   <= 1'b0;
    end else begin
      res_vld    <= rx_addr_vld;
      res_accept <= rx_addr_vld && decide;
      res_exact  <= rx_addr_vld && slot_hit;
      res_slot   <= rx_addr_vld ? slot_idx : '0;
      res_hash   <= rx_addr_vld && hash_ok;
    end
  end
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker #(
  parameter int NSLOT = 8,
  localparam int UW = $clog2(NSLOT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_addr_vld,
  input logic [47:0]   rx_addr,
  input logic          res_vld,
  input logic          res_accept,
  input logic          res_exact,
  input logic          res_hash,
  input logic          mode_promisc,
  input logic          mode_hash_en,
  input logic          mode_bcast_dis,
  input logic [UW-1:0] ucnt_q
);
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr_vld |=> res_vld);
  a_r1_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_addr_vld |=> !res_vld);
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    ucnt_q <= UW'(NSLOT));
  a_r8_hash_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr_vld && (!mode_hash_en || !rx_addr[0]) |=> !res_hash);
  a_r9_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr_vld && mode_promisc |=> res_accept);
  a_r10_bcast_block: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr_vld && !mode_promisc && mode_bcast_dis && (&rx_addr) |=> !res_accept);
  a_r10_reason: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr_vld && !mode_promisc && !(&rx_addr) |=> res_accept == (res_exact || res_hash));
endmodule

bind rx_dest_filter rdf_checker #(.NSLOT(NSLOT)) u_rdf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_addr_vld    (rx_addr_vld),
  .rx_addr        (rx_addr),
  .res_vld        (res_vld),
  .res_accept     (res_accept),
  .res_exact      (res_exact),
  .res_hash       (res_hash),
  .mode_promisc   (mode_promisc),
  .mode_hash_en   (mode_hash_en),
  .mode_bcast_dis (mode_bcast_dis),
  .ucnt_q         (ucnt_q)
);

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_addr_vld = 1'b0;
  logic [47:0] rx_addr = '0;
  logic        res_vld, res_accept, res_exact, res_hash;
  logic [2:0]  res_slot;

  int tests = 0, fails = 0;
  string cur_req = "R11";

  // reference state
  logic [31:0] m_lo [8];
  logic [15:0] m_hi [8];
  bit          m_val [8];
  logic [63:0] m_tab;
  bit          m_prom, m_hen, m_bdis;
  int          m_ucnt;
  // pending expectation
  bit          p_vld, p_acc, p_ex, p_hs;
  int          p_slot;

  always #10 clk = ~clk;

  rx_dest_filter i_rx_dest_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_addr_vld(rx_addr_vld), .rx_addr(rx_addr),
    .res_vld(res_vld), .res_accept(res_accept), .res_exact(res_exact),
    .res_slot(res_slot), .res_hash(res_hash));

  function automatic int bin_of(logic [47:0] a);
    int h = 0, pos = 0;
    for (int by = 0; by < 6; by++)
      for (int bi = 0; bi < 8; bi++) begin
        if (a[by*8+bi]) h = h ^ (1 << pos);
        pos = (pos == 5) ? 0 : pos + 1;
      end
    return h;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 8; k++) begin m_lo[k] = '0; m_hi[k] = '0; m_val[k] = 0; end
    m_tab = '0; m_prom = 0; m_hen = 0; m_bdis = 0; m_ucnt = 1;
    p_vld = 0;
  endtask

  task automatic model_eval(logic [47:0] a);
    bit mc = a[0];
    p_ex = 0; p_slot = 0;
    for (int k = 0; k < 8; k++)
      if (!p_ex && m_val[k] && {m_hi[k], m_lo[k]} == a && ((k < m_ucnt) ? !mc : mc)) begin
        p_ex = 1; p_slot = k;
      end
    p_hs  = mc && m_hen && m_tab[bin_of(a)];
    p_acc = m_prom || ((a == '1) ? !m_bdis : (p_ex || p_hs));
  endtask

  task automatic model_write(logic [4:0] wa, logic [31:0] wd);
    if (wa < 16) begin
      if (!wa[0]) begin m_lo[wa>>1] = wd; m_val[wa>>1] = 0; end
      else begin
        m_hi[wa>>1]  = wd[15:0];
        m_val[wa>>1] = (wd[15:0] != 0) || (m_lo[wa>>1] != 0);
      end
    end else if (wa == 16) m_tab[31:0] = wd;
    else if (wa == 17) m_tab[63:32] = wd;
    else if (wa == 18) begin m_prom = wd[0]; m_hen = wd[1]; m_bdis = wd[2]; end
    else if (wa == 19 && wd <= 8) m_ucnt = int'(wd);
  endtask

  task automatic check_now();
    bit bad;
    tests++;
    bad = (res_vld !== p_vld);
    if (p_vld)
      bad = bad || (res_accept !== p_acc) || (res_exact !== p_ex) || (res_hash !== p_hs) ||
            (p_ex && res_slot !== 3'(p_slot));
    if (bad) begin
      fails++;
      $display("FAIL %s: got vld=%0b acc=%0b ex=%0b slot=%0d hs=%0b exp vld=%0b acc=%0b ex=%0b slot=%0d hs=%0b",
               cur_req, res_vld, res_accept, res_exact, res_slot, res_hash,
               p_vld, p_acc, p_ex, p_slot, p_hs);
    end
  endtask

  // One clock: check previous result, drive new inputs, update the model.
  task automatic cyc(bit v, logic [47:0] a, bit we, logic [4:0] wa, logic [31:0] wd);
    @(negedge clk);
    check_now();
    rx_addr_vld = v; rx_addr = a; cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    p_vld = v;
    if (v) model_eval(a);
    if (we) model_write(wa, wd);
  endtask

  task automatic wr(logic [4:0] wa, logic [31:0] wd); cyc(0, '0, 1, wa, wd); endtask
  task automatic look(logic [47:0] a); cyc(1, a, 0, '0, '0); endtask
  task automatic load_slot(int k, logic [47:0] a);
    wr(5'(2*k), a[31:0]); wr(5'(2*k+1), {16'h0, a[47:32]});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [47:0] STA = 48'h0E0D_0C0B_0A02;  // byte0 = 02 (unicast)
  localparam logic [47:0] GRP = 48'h5544_3322_1101;  // byte0 = 01 (multicast)

  initial begin
    logic [47:0] a;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    cur_req = "R11";
    cyc(0, '0, 0, '0, '0);
    look(STA); look(GRP); look('1); look('0);
    // R1: idle cycle after strobe, back-to-back strobes
    cur_req = "R1";
    cyc(0, '0, 0, '0, '0); look(STA); look(STA); cyc(0, '0, 0, '0, '0);
    // R2: byte layout of slot words
    cur_req = "R2";
    wr(0, 32'h0B0A_0C02); wr(1, 32'h0000_0E0D);  // wrong order in low word
    look(STA);
    load_slot(0, STA); look(STA); look(48'h020A_0B0C_0D0E);
    // R3: half-written and zeroed slots
    cur_req = "R3";
    wr(0, STA[31:0]); look(STA);
    wr(1, {16'h0, STA[47:32]}); look(STA);
    wr(19, 8); wr(6, 0); wr(7, 0); look('0); wr(19, 1);
    // R4: unicast count partitions slots
    cur_req = "R4";
    load_slot(2, GRP); look(GRP);
    wr(19, 3); look(GRP);
    wr(19, 9); look(GRP); wr(19, 32'h8000_0002); look(GRP);
    wr(19, 1); look(GRP);
    wr(19, 0); look(STA); wr(19, 1);
    // R5: lowest index wins
    cur_req = "R5";
    load_slot(5, GRP); look(GRP); wr(4, 0); look(GRP);
    // R6 / R7 / R8: hash bins on both words
    cur_req = "R6";
    for (int i = 0; i < 24; i++) begin
      a = {$urandom, $urandom} | 48'h1;
      wr(16, '0); wr(17, '0);
      if (bin_of(a) < 32) wr(16, 32'h1 << bin_of(a)); else wr(17, 32'h1 << (bin_of(a) - 32));
      wr(18, 32'h2); look(a);
      cur_req = (bin_of(a) >= 32) ? "R7" : "R6";
    end
    cur_req = "R8";
    a = {$urandom, $urandom} & ~48'h1;
    wr(16, '1); wr(17, '1); look(a); look(a | 48'h1);
    wr(18, 0); look(a | 48'h1); wr(18, 2);
    // R10: broadcast handling
    cur_req = "R10";
    look('1); wr(18, 32'h6); look('1); look(48'h3); wr(18, 0); look('1);
    // R9: copy-all
    cur_req = "R9";
    wr(18, 32'h5);
    for (int i = 0; i < 8; i++) look({$urandom, $urandom});
    look('1); wr(18, 0);
    // R12: writes concurrent with lookups
    cur_req = "R12";
    cyc(1, STA, 1, 0, 32'h0); cyc(1, STA, 1, 1, 32'h0); look(STA);
    cyc(1, 48'h7, 1, 18, 32'h1); cyc(1, 48'h7, 1, 18, 32'h0); look(48'h7);
    load_slot(0, STA);
    // mixed random traffic
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom % 3) != 0;
      bit w = ($urandom % 3) == 0;
      logic [4:0]  wa = 5'($urandom % 20);
      logic [31:0] wd = ($urandom % 4 == 0) ? 32'($urandom % 10) : $urandom;
      a = ($urandom % 4 == 0) ? {m_hi[$urandom % 8], m_lo[$urandom % 8]} : {$urandom, $urandom};
      if (wa == 18) wd = wd & 32'h6;
      cyc(v, a, w, wa, wd);
    end
    cyc(0, '0, 0, '0, '0);
    cyc(0, '0, 0, '0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule